// File: doc/BRIEF.md
# I2C Event Flag Controller

This block keeps the status flags of an I2C peripheral and merges them into one interrupt request. A protocol engine, which is not part of this block, drives one-cycle event pulses into it: start sent, address matched, 10-bit header sent, byte transfer done, stop detected, acknowledge failure, arbitration lost and bus error. Software reaches the block over a small register bus that has separate read and write strobes. The bus selects one of four registers: a primary status register, a secondary status register, a data register and a control register.

A flag is never cleared by writing a one to it. Each flag clears only after its own sequence of register accesses. Reading the primary status register arms a one-deep sequence tracker. The access that comes next either completes a clear sequence or disarms the tracker. The secondary status register clears its flags when it is read. A summary flag is high whenever any flag is pending. The interrupt output follows the summary flag, gated by a control-register enable bit, an external global mask and the power mode. The data width `DW` must be at least 8.

Top module: `i2c_evt_flags`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every flag, the tracker, the data and control registers, and `irqOut`. After reset, `evtFlag` and `irqOut` are 0.
- R2: The start-sent flag (primary status bit 0) clears only when an armed tracker sees a data-register write.
- R3: The address-matched flag (primary status bit 1) clears only when an armed tracker sees a control-register write.
- R4: The byte-transfer flag (primary status bit 3) records `rxMode` in primary status bit 4 when it sets. If that bit is 1 (receive), the flag clears when an armed tracker sees a data-register read. If that bit is 0 (transmit), the flag clears when an armed tracker sees a data-register write. The other data access leaves the flag set.
- R5: The 10-bit-header flag (primary status bit 2) clears when an armed tracker sees a data-register write.
- R6: A read of the secondary status register (address 1) clears stop (bit 0), acknowledge failure (bit 1), arbitration lost (bit 2) and bus error (bit 3). No tracker is needed for this clear.
- R7: An event pulse sets its flag at the next clock edge. `evtFlag`, which is also primary status bit 7, is the OR of all eight flags.
- R8: `irqOut` is a register. It loads `evtFlag & intEnable & !globalMask & !halt`, where intEnable is control bit 0. The interrupt therefore follows its causes by one cycle.
- R9: Wait mode (`powerMode` = 2'b01) has no effect on the block. In halt mode (`powerMode[1]` = 1), event pulses are ignored and `irqOut` is held low.
- R10: If an event pulse arrives in the same cycle as a clear of its flag, the flag stays set.
- R11: A primary status read (address 0) arms the tracker. Any other access disarms it without clearing anything on the tracker path. A second primary status read re-arms it. With no bus access, no flag clears.
- R12: The address map is: 0 primary status, 1 secondary status, 2 data, 3 control. The data and control registers read back the last value written to them. If `busRd` and `busWr` are both high, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evStart | input | 1 | Start-sent event pulse |
| evAddrMatch | input | 1 | Address-matched event pulse |
| evHdr10 | input | 1 | 10-bit header sent event pulse |
| evXferDone | input | 1 | Byte transfer done event pulse |
| evStop | input | 1 | Stop detected event pulse |
| evAckFail | input | 1 | Acknowledge failure event pulse |
| evArbLost | input | 1 | Arbitration lost event pulse |
| evBusErr | input | 1 | Bus error event pulse |
| rxMode | input | 1 | Transfer direction (1 = receive), captured when the byte-transfer flag sets |
| powerMode | input | 2 | 00 run, 01 wait, 1x halt |
| globalMask | input | 1 | Global interrupt mask; 1 blocks the interrupt |
| busRd | input | 1 | Register read strobe |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register select |
| busWdata | input | DW | Write data |
| busRdata | output | DW | Read data for the selected register, combinational |
| evtFlag | output | 1 | Summary flag: any flag pending |
| irqOut | output | 1 | Gated interrupt request |

## Verification
The bench builds the block with `DW` = 8. At that width the status layout fills a whole word, including the summary bit at position 7. The data and control registers can then be loaded with any full-width pattern, so the bench exercises every readback bit. Directed sequences cover each clear path, including the wrong-direction transfer accesses, disarming by an intervening access, re-arming, and a set and clear that land in the same cycle. A long random phase then mixes sparse events, power modes and mask changes with bus traffic, and every cycle is compared against the reference model.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int NFLAG = 8;

  // flag positions; primary status shows 0..3, secondary shows 4..7 as bits 0..3
  localparam int F_START = 0;
  localparam int F_ADDR  = 1;
  localparam int F_HDR10 = 2;
  localparam int F_XFER  = 3;
  localparam int F_STOP  = 4;
  localparam int F_ACKF  = 5;
  localparam int F_ARBL  = 6;
  localparam int F_BERR  = 7;

  localparam int ST1_RX_BIT  = 4;
  localparam int ST1_EVT_BIT = 7;
  localparam int CTRL_IE_BIT = 0;

  typedef enum logic [1:0] {
    REG_STAT1 = 2'd0,
    REG_STAT2 = 2'd1,
    REG_DATA  = 2'd2,
    REG_CTRL  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic dataWrStep;
    logic dataRdStep;
    logic ctrlWrStep;
    logic stat2Rd;
    logic dataWr;
    logic ctrlWr;
  } evtStrobe_t;
endpackage

// File: rtl/i2c_evt_seq.sv
module i2c_evt_seq
  import i2c_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       busRd,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  output evtStrobe_t strb
);
  logic armed;
  logic wrAcc;
  logic rdAcc;
  logic anyAcc;
  regSel_e sel;

  assign sel    = regSel_e'(busAddr);
  assign wrAcc  = busWr;
  assign rdAcc  = busRd & ~busWr;
  assign anyAcc = busRd | busWr;

  always_comb begin
    strb            = '0;
    strb.dataWr     = wrAcc & (sel == REG_DATA);
    strb.ctrlWr     = wrAcc & (sel == REG_CTRL);
    strb.stat2Rd    = rdAcc & (sel == REG_STAT2);
    strb.dataWrStep = armed & wrAcc & (sel == REG_DATA);
    strb.dataRdStep = armed & rdAcc & (sel == REG_DATA);
    strb.ctrlWrStep = armed & wrAcc & (sel == REG_CTRL);
  end

  // tracker: any access re-decides it; only a primary status read arms
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (anyAcc) begin
      armed <= rdAcc & (sel == REG_STAT1);
    end
  end
endmodule

// File: rtl/i2c_evt_dp.sv
module i2c_evt_dp
  import i2c_evt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] evtIn,
  input  logic             rxMode,
  input  logic [1:0]       powerMode,
  input  logic             globalMask,
  input  logic [1:0]       busAddr,
  input  logic [DW-1:0]    busWdata,
  input  evtStrobe_t       strb,
  output logic [DW-1:0]    busRdata,
  output logic             evtFlag,
  output logic             irqOut
);
  localparam int NSEC = NFLAG - F_STOP;

  logic             haltNow;
  logic [NFLAG-1:0] setVec;
  logic [NFLAG-1:0] clrVec;
  logic [NFLAG-1:0] flags;
  logic             xferRx;
  logic [DW-1:0]    dataReg;
  logic [DW-1:0]    ctrlReg;
  logic             irqQ;

  assign haltNow = powerMode[1];
  assign setVec  = haltNow ? '0 : evtIn;

  always_comb begin
    clrVec = '0;
    if (strb.dataWrStep) begin
      clrVec[F_START] = 1'b1;
      clrVec[F_HDR10] = 1'b1;
      if (!xferRx) clrVec[F_XFER] = 1'b1;
    end
    if (strb.dataRdStep && xferRx) clrVec[F_XFER] = 1'b1;
    if (strb.ctrlWrStep) clrVec[F_ADDR] = 1'b1;
    if (strb.stat2Rd) clrVec[NFLAG-1:F_STOP] = '1;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= setVec[i] | (q & ~clrVec[i]);
    end
    assign flags[i] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xferRx  <= 1'b0;
      dataReg <= '0;
      ctrlReg <= '0;
      irqQ    <= 1'b0;
    end else begin
      if (setVec[F_XFER]) xferRx <= rxMode;
      if (strb.dataWr) dataReg <= busWdata;
      if (strb.ctrlWr) ctrlReg <= busWdata;
      irqQ <= evtFlag & ctrlReg[CTRL_IE_BIT] & ~globalMask & ~haltNow;
    end
  end

  assign evtFlag = |flags;
  assign irqOut  = irqQ;

  always_comb begin
    busRdata = '0;
    unique case (regSel_e'(busAddr))
      REG_STAT1: begin
        busRdata[F_XFER:0]      = flags[F_XFER:0];
        busRdata[ST1_RX_BIT]    = xferRx;
        busRdata[ST1_EVT_BIT]   = evtFlag;
      end
      REG_STAT2: busRdata[NSEC-1:0] = flags[NFLAG-1:F_STOP];
      REG_DATA:  busRdata = dataReg;
      REG_CTRL:  busRdata = ctrlReg;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags
  import i2c_evt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evStart,
  input  logic          evAddrMatch,
  input  logic          evHdr10,
  input  logic          evXferDone,
  input  logic          evStop,
  input  logic          evAckFail,
  input  logic          evArbLost,
  input  logic          evBusErr,
  input  logic          rxMode,
  input  logic [1:0]    powerMode,
  input  logic          globalMask,
  input  logic          busRd,
  input  logic          busWr,
  input  logic [1:0]    busAddr,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  output logic          evtFlag,
  output logic          irqOut
);
  evtStrobe_t       strb;
  logic [NFLAG-1:0] evtIn;

  always_comb begin
    evtIn          = '0;
    evtIn[F_START] = evStart;
    evtIn[F_ADDR]  = evAddrMatch;
    evtIn[F_HDR10] = evHdr10;
    evtIn[F_XFER]  = evXferDone;
    evtIn[F_STOP]  = evStop;
    evtIn[F_ACKF]  = evAckFail;
    evtIn[F_ARBL]  = evArbLost;
    evtIn[F_BERR]  = evBusErr;
  end

  i2c_evt_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .busRd   (busRd),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb)
  );

  i2c_evt_dp #(.DW(DW)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .evtIn      (evtIn),
    .rxMode     (rxMode),
    .powerMode  (powerMode),
    .globalMask (globalMask),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .strb       (strb),
    .busRdata   (busRdata),
    .evtFlag    (evtFlag),
    .irqOut     (irqOut)
  );
endmodule

// File: rtl/i2c_evt_flags_chk.sv
module i2c_evt_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic       evStart,
  input logic       evAddrMatch,
  input logic       evHdr10,
  input logic       evXferDone,
  input logic       evStop,
  input logic       evAckFail,
  input logic       evArbLost,
  input logic       evBusErr,
  input logic [1:0] powerMode,
  input logic       globalMask,
  input logic       busRd,
  input logic       busWr,
  input logic       evtFlag,
  input logic       irqOut
);
  logic anyEv;
  assign anyEv = evStart | evAddrMatch | evHdr10 | evXferDone |
                 evStop | evAckFail | evArbLost | evBusErr;

  // R7 / R10: an accepted event always leaves the summary flag high
  p_event_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (!powerMode[1] && anyEv) |=> evtFlag);

  // R8: interrupt only follows an unmasked pending flag outside halt
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> $past(evtFlag && !globalMask && !powerMode[1]));

  // R9: halt silences the interrupt
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    powerMode[1] |=> !irqOut);

  // R11: flags only drop after a bus access
  p_clear_needs_access_r11: assert property (@(posedge clk) disable iff (rst)
    ($fell(evtFlag) && !$past(rst)) |-> $past(busRd || busWr));
endmodule

bind i2c_evt_flags i2c_evt_flags_chk u_chk (.*);

// File: tb/i2c_evt_flags_test.sv
module i2c_evt_flags_test;
  localparam int DW = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    evIn = '0;
  logic          rxMode = 1'b0;
  logic [1:0]    powerMode = 2'b00;
  logic          globalMask = 1'b0;
  logic          busRd = 1'b0;
  logic          busWr = 1'b0;
  logic [1:0]    busAddr = 2'd0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          evtFlag;
  logic          irqOut;

  int    nChecks = 0;
  int    nFails  = 0;
  int    cycles  = 0;
  bit    done    = 0;
  string reqTag  = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_evt_flags #(.DW(DW)) uut (
    .clk(clk), .rst(rst),
    .evStart(evIn[0]), .evAddrMatch(evIn[1]), .evHdr10(evIn[2]),
    .evXferDone(evIn[3]), .evStop(evIn[4]), .evAckFail(evIn[5]),
    .evArbLost(evIn[6]), .evBusErr(evIn[7]),
    .rxMode(rxMode), .powerMode(powerMode), .globalMask(globalMask),
    .busRd(busRd), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .evtFlag(evtFlag), .irqOut(irqOut)
  );

  // behavioural reference model
  bit [7:0]    mFlags;
  bit          mRx, mArmed, mIrq;
  bit [DW-1:0] mData, mCtrl;
  bit          isRd, isWr;
  int          a;
  bit [7:0]    clr, setv;

  always @(posedge clk) begin
    if (rst) begin
      mFlags = 0; mRx = 0; mArmed = 0; mIrq = 0; mData = 0; mCtrl = 0;
    end else begin
      isWr = busWr;
      isRd = busRd && !busWr;
      a    = int'(busAddr);
      clr  = 0;
      if (mArmed && isWr && a == 2) begin
        clr[0] = 1; clr[2] = 1;
        if (!mRx) clr[3] = 1;
      end
      if (mArmed && isRd && a == 2 && mRx) clr[3] = 1;
      if (mArmed && isWr && a == 3) clr[1] = 1;
      if (isRd && a == 1) clr[7:4] = 4'hF;
      setv = powerMode[1] ? 8'h00 : evIn;
      mIrq = (mFlags != 0) && mCtrl[0] && !globalMask && !powerMode[1];
      if (setv[3]) mRx = rxMode;
      mFlags = setv | (mFlags & ~clr);
      if (isRd || isWr) mArmed = isRd && a == 0;
      if (isWr && a == 2) mData = busWdata;
      if (isWr && a == 3) mCtrl = busWdata;
    end
  end

  function automatic logic [DW-1:0] expRd();
    logic [DW-1:0] r;
    r = '0;
    case (busAddr)
      2'd0: begin r[3:0] = mFlags[3:0]; r[4] = mRx; r[7] = (mFlags != 0); end
      2'd1: r[3:0] = mFlags[7:4];
      2'd2: r = mData;
      default: r = mCtrl;
    endcase
    return r;
  endfunction

  task automatic chk1(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", reqTag, what, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    chk1("evtFlag", DW'(evtFlag), DW'(mFlags != 0));
    chk1("irqOut", DW'(irqOut), DW'(mIrq));
    chk1("busRdata", busRdata, expRd());
  endtask

  task automatic cyc();
    @(negedge clk);
    cycles++;
    compareAll();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse(logic [7:0] v);
    evIn = v; cyc(); evIn = '0;
  endtask

  task automatic acc(bit rd, bit wr, logic [1:0] ad, logic [DW-1:0] wd);
    busRd = rd; busWr = wr; busAddr = ad; busWdata = wd;
    cyc();
    busRd = 0; busWr = 0; busWdata = '0;
  endtask

  task automatic look(logic [1:0] ad);
    busAddr = ad; cyc();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cycles > WATCHDOG && !done) begin
        nFails++; nChecks++;
        $display("FAIL watchdog expired: actual %0d expected below %0d cycles", cycles, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset state
    reqTag = "R1";
    idle(3);
    rst = 0;
    look(2'd0); look(2'd1); look(2'd2); look(2'd3);

    // R12: register map, readback, write precedence
    reqTag = "R12";
    acc(0, 1, 2'd2, 8'hA5); look(2'd2);
    acc(0, 1, 2'd3, 8'h5A); look(2'd3);
    acc(1, 1, 2'd2, 8'h3C); look(2'd2);
    acc(0, 1, 2'd3, 8'h00);

    // R7: set and summary
    reqTag = "R7";
    pulse(8'h01); look(2'd0);
    // R2: start clear
    reqTag = "R2";
    acc(1, 0, 2'd0, 0); acc(0, 1, 2'd2, 8'h11); look(2'd0);

    // R11: disarm and re-arm
    reqTag = "R11";
    pulse(8'h01);
    acc(1, 0, 2'd0, 0); acc(1, 0, 2'd1, 0); acc(0, 1, 2'd2, 8'h22); look(2'd0);
    idle(3);
    acc(1, 0, 2'd0, 0); acc(1, 0, 2'd0, 0); acc(0, 1, 2'd2, 8'h33); look(2'd0);

    // R3: address match
    reqTag = "R3";
    pulse(8'h02);
    acc(1, 0, 2'd0, 0); acc(0, 1, 2'd2, 8'h01); look(2'd0);
    acc(1, 0, 2'd0, 0); acc(0, 1, 2'd3, 8'h00); look(2'd0);

    // R4: transfer, receive then transmit
    reqTag = "R4";
    rxMode = 1; pulse(8'h08); rxMode = 0; look(2'd0);
    acc(1, 0, 2'd0, 0); acc(0, 1, 2'd2, 8'h44); look(2'd0);
    acc(1, 0, 2'd0, 0); acc(1, 0, 2'd2, 0); look(2'd0);
    pulse(8'h08);
    acc(1, 0, 2'd0, 0); acc(1, 0, 2'd2, 0); look(2'd0);
    acc(1, 0, 2'd0, 0); acc(0, 1, 2'd2, 8'h55); look(2'd0);

    // R5: 10-bit header
    reqTag = "R5";
    pulse(8'h04);
    acc(1, 0, 2'd0, 0); acc(0, 1, 2'd2, 8'h66); look(2'd0);

    // R6: secondary status read-clear
    reqTag = "R6";
    pulse(8'hF0); look(2'd1);
    acc(1, 0, 2'd1, 0); look(2'd1);

    // R8: interrupt gating
    reqTag = "R8";
    acc(0, 1, 2'd3, 8'h01);
    pulse(8'h10); idle(2);
    globalMask = 1; idle(2);
    globalMask = 0; idle(2);
    acc(0, 1, 2'd3, 8'h00); idle(2);
    acc(0, 1, 2'd3, 8'h01); idle(1);

    // R9: wait and halt
    reqTag = "R9";
    acc(1, 0, 2'd1, 0); idle(1);
    powerMode = 2'b01; pulse(8'h20); idle(2);
    powerMode = 2'b10; idle(2);
    acc(1, 0, 2'd1, 0);
    pulse(8'hFF); look(2'd0); look(2'd1);
    powerMode = 2'b11; pulse(8'h01); idle(1);
    powerMode = 2'b00; idle(2);

    // R10: set beats clear
    reqTag = "R10";
    pulse(8'h01);
    acc(1, 0, 2'd0, 0);
    evIn = 8'h01; acc(0, 1, 2'd2, 8'h77); evIn = 0; look(2'd0);
    pulse(8'h10);
    evIn = 8'h10; acc(1, 0, 2'd1, 0); evIn = 0; look(2'd1);
    acc(1, 0, 2'd1, 0);
    acc(1, 0, 2'd0, 0); acc(0, 1, 2'd2, 8'h00); idle(2);

    // R7: random mix of events, modes and traffic
    reqTag = "R7";
    for (int i = 0; i < 4000; i++) begin
      evIn       = ($urandom_range(0, 7) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
      rxMode     = 1'($urandom_range(0, 1));
      powerMode  = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
      globalMask = ($urandom_range(0, 9) == 0);
      busRd      = ($urandom_range(0, 2) == 0);
      busWr      = ($urandom_range(0, 3) == 0);
      busAddr    = 2'($urandom_range(0, 3));
      busWdata   = DW'($urandom);
      cyc();
    end
    evIn = 0; busRd = 0; busWr = 0; powerMode = 0; globalMask = 0;
    idle(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule